// File: doc/BRIEF.md
# I2C Line Glitch Filter

This block cleans up the two wires of an I2C bus before the bus master logic looks at them. Each wire, clock (SCL) and data (SDA), first passes through a two-flop synchronizer. It then enters its own stability filter. A new level reaches the filtered output only after the synchronized input has held that level for a programmable number of core clock cycles. Shorter disturbances are discarded.

Each wire has its own enable and its own 3-bit threshold, so the two wires can be tuned separately. When a wire's filter is turned off, the synchronized level is registered straight through. Filtering stretches the clock wire's path. The block therefore also reports, as a registered count, how many core clocks that path adds. Timing logic downstream subtracts this count from its clock-high period.

Top module: `i2c_line_filter`

## Requirements
- R1: While reset is asserted, both filtered outputs are 1 and the reported compensation is 13.
- R2: With a wire's filter disabled, a level change on its input reaches its output on the third rising clock edge after the change, and a change lasting one cycle is passed.
- R3: With a wire's filter enabled and threshold T in 1..7, a level change that persists reaches the output on clock edge T+2 after the input change, and never earlier.
- R4: With the filter enabled, an input pulse lasting fewer than T clock cycles never changes the output, while a pulse of exactly T cycles is passed.
- R5: The stability count restarts whenever the synchronized input returns to the output level, so two sub-threshold pulses separated by one cycle do not add up.
- R6: A threshold of 0 behaves like a threshold of 1.
- R7: SCL and SDA use separate enables and thresholds; a glitch applied to both wires at once is judged by each wire's own settings.
- R8: The compensation output equals 7 when the SCL filter is disabled, 8 for SCL thresholds 0 to 2, and threshold+6 for thresholds 3 to 7. It is updated one clock edge after the configuration changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw clock wire level |
| sda_in | input | 1 | Raw data wire level |
| scl_filt_en | input | 1 | 1 enables the SCL stability filter |
| sda_filt_en | input | 1 | 1 enables the SDA stability filter |
| scl_thr | input | 3 | SCL stability threshold in core clocks |
| sda_thr | input | 3 | SDA stability threshold in core clocks |
| scl_out | output | 1 | Filtered clock wire level |
| sda_out | output | 1 | Filtered data wire level |
| scl_comp | output | 4 | Core clocks the filter adds on the SCL path |

## Verification
The assertions assume that the enables and thresholds are quasi-static. They may change between clock edges, but each property compares against the configuration sampled on the previous edge. The minimum-run property also assumes that the raw wires are driven only at settled logic levels. The bench respects both assumptions. It changes configuration and wire levels only at falling clock edges, and it lets every pulse finish before it changes a threshold or an enable.

// File: rtl/i2c_filt_pkg.sv
package i2c_filt_pkg;

  // Core clocks added on the SCL path for a given filter setting.
  function automatic int unsigned scl_path_delay(input logic en, input int unsigned thr);
    if (!en)
      return 7;
    else if (thr <= 2)
      return 8;
    else
      return thr + 6;
  endfunction

endpackage

// File: rtl/i2c_sync_chain.sv
module i2c_sync_chain #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst)
      chain_q <= {STAGES{RST_VAL}};
    else
      chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_line_deglitch.sv
module i2c_line_deglitch #(
  parameter int   THR_W   = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [THR_W-1:0] thr,
  input  logic             lvl_sync,
  output logic             lvl_filt
);

  localparam int CW = THR_W + 1;

  logic [THR_W-1:0] run_q;
  logic [CW-1:0]    need;
  logic [CW-1:0]    run_next;

  // A zero threshold still needs one observed cycle.
  assign need     = (thr == '0) ? CW'(1) : {1'b0, thr};
  assign run_next = {1'b0, run_q} + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_filt <= RST_VAL;
      run_q    <= '0;
    end else if (!en) begin
      lvl_filt <= lvl_sync;
      run_q    <= '0;
    end else if (lvl_sync == lvl_filt) begin
      run_q    <= '0;
    end else if (run_next >= need) begin
      lvl_filt <= lvl_sync;
      run_q    <= '0;
    end else begin
      run_q    <= run_next[THR_W-1:0];
    end
  end

endmodule

// File: rtl/i2c_delay_report.sv
module i2c_delay_report #(
  parameter int THR_W  = 3,
  parameter int COMP_W = 4,
  parameter int DEF_THR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [THR_W-1:0]  thr,
  output logic [COMP_W-1:0] comp
);

  import i2c_filt_pkg::*;

  localparam logic [COMP_W-1:0] RST_COMP = COMP_W'(scl_path_delay(1'b1, DEF_THR));

  logic [COMP_W-1:0] comp_d;

  always_comb comp_d = COMP_W'(scl_path_delay(en, int'(thr)));

  always_ff @(posedge clk) begin
    if (rst)
      comp <= RST_COMP;
    else
      comp <= comp_d;
  end

endmodule

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int THR_W   = 3,
  parameter int COMP_W  = 4,
  parameter int SYNC_N  = 2,
  parameter int DEF_THR = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              scl_filt_en,
  input  logic              sda_filt_en,
  input  logic [THR_W-1:0]  scl_thr,
  input  logic [THR_W-1:0]  sda_thr,
  output logic              scl_out,
  output logic              sda_out,
  output logic [COMP_W-1:0] scl_comp
);

  localparam int NLINES = 2;

  logic [NLINES-1:0]            raw_lvl;
  logic [NLINES-1:0]            sync_lvl;
  logic [NLINES-1:0]            filt_lvl;
  logic [NLINES-1:0]            line_en;
  logic [NLINES-1:0][THR_W-1:0] line_thr;

  // Index 0 is SCL, index 1 is SDA.
  assign raw_lvl  = {sda_in, scl_in};
  assign line_en  = {sda_filt_en, scl_filt_en};
  assign line_thr = {sda_thr, scl_thr};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2c_sync_chain #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lvl[i]),
      .dout (sync_lvl[i])
    );
    i2c_line_deglitch #(.THR_W(THR_W), .RST_VAL(1'b1)) i_dg (
      .clk      (clk),
      .rst      (rst),
      .en       (line_en[i]),
      .thr      (line_thr[i]),
      .lvl_sync (sync_lvl[i]),
      .lvl_filt (filt_lvl[i])
    );
  end

  assign scl_out = filt_lvl[0];
  assign sda_out = filt_lvl[1];

  i2c_delay_report #(.THR_W(THR_W), .COMP_W(COMP_W), .DEF_THR(DEF_THR)) i_dly (
    .clk  (clk),
    .rst  (rst),
    .en   (scl_filt_en),
    .thr  (scl_thr),
    .comp (scl_comp)
  );

endmodule

// File: rtl/i2c_line_filter_chk.sv
module i2c_line_filter_chk #(
  parameter int THR_W  = 3,
  parameter int COMP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_filt_en,
  input logic              sda_filt_en,
  input logic [THR_W-1:0]  scl_thr,
  input logic [THR_W-1:0]  sda_thr,
  input logic              scl_sync,
  input logic              sda_sync,
  input logic              scl_out,
  input logic              sda_out,
  input logic [COMP_W-1:0] scl_comp
);

  // Consecutive cycles in which the synchronized level disagreed with the output.
  logic [4:0] scl_run, sda_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_run <= '0;
      sda_run <= '0;
    end else begin
      if (scl_sync != scl_out) scl_run <= (scl_run == 5'd31) ? scl_run : scl_run + 5'd1;
      else                     scl_run <= '0;
      if (sda_sync != sda_out) sda_run <= (sda_run == 5'd31) ? sda_run : sda_run + 5'd1;
      else                     sda_run <= '0;
    end
  end

  function automatic int unsigned min_run(input logic [THR_W-1:0] t);
    return (t == '0) ? 1 : int'(t);
  endfunction

  function automatic int unsigned exp_comp(input logic en, input logic [THR_W-1:0] t);
    if (!en) return 7;
    if (t < 3) return 8;
    return int'(t) + 6;
  endfunction

  assert_scl_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(scl_filt_en)) |-> (scl_out == $past(scl_sync)));

  assert_sda_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sda_filt_en)) |-> (sda_out == $past(sda_sync)));

  assert_scl_min_run_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(scl_filt_en) && !$stable(scl_out))
      |-> (int'($past(scl_run)) + 1 >= min_run($past(scl_thr))));

  assert_sda_min_run_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sda_filt_en) && !$stable(sda_out))
      |-> (int'($past(sda_run)) + 1 >= min_run($past(sda_thr))));

  assert_comp_value_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(scl_comp) == exp_comp($past(scl_filt_en), $past(scl_thr))));

endmodule

bind i2c_line_filter i2c_line_filter_chk #(.THR_W(THR_W), .COMP_W(COMP_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .scl_filt_en (scl_filt_en),
  .sda_filt_en (sda_filt_en),
  .scl_thr     (scl_thr),
  .sda_thr     (sda_thr),
  .scl_sync    (sync_lvl[0]),
  .sda_sync    (sync_lvl[1]),
  .scl_out     (scl_out),
  .sda_out     (sda_out),
  .scl_comp    (scl_comp)
);

// File: tb/test_i2c_line_filter.sv
`timescale 1ns/1ps
module test_i2c_line_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       scl_filt_en = 1'b1, sda_filt_en = 1'b1;
  logic [2:0] scl_thr = 3'd7, sda_thr = 3'd7;
  logic       scl_out, sda_out;
  logic [3:0] scl_comp;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  i2c_line_filter i_i2c_line_filter (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_filt_en(scl_filt_en), .sda_filt_en(sda_filt_en),
    .scl_thr(scl_thr), .sda_thr(sda_thr),
    .scl_out(scl_out), .sda_out(sda_out), .scl_comp(scl_comp)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive a low pulse of len cycles on the chosen wire (0 = SCL, 1 = SDA),
  // then watch 14 cycles and report whether the output went low.
  task automatic pulse_seen(input int line, input int len, output bit seen);
    seen = 1'b0;
    if (line == 0) scl_in = 1'b0; else sda_in = 1'b0;
    for (int i = 0; i < len; i++) begin
      tick(1);
      if ((line == 0 ? scl_out : sda_out) == 1'b0) seen = 1'b1;
    end
    if (line == 0) scl_in = 1'b1; else sda_in = 1'b1;
    for (int i = 0; i < 14; i++) begin
      tick(1);
      if ((line == 0 ? scl_out : sda_out) == 1'b0) seen = 1'b1;
    end
  endtask

  // Step the wire low and measure the edge on which the output follows.
  task automatic step_latency(input int line, input int d, input string req);
    if (line == 0) scl_in = 1'b0; else sda_in = 1'b0;
    tick(1 + d);
    chk({req, " not yet"}, int'(line == 0 ? scl_out : sda_out), 1);
    tick(1);
    chk({req, " followed"}, int'(line == 0 ? scl_out : sda_out), 0);
    if (line == 0) scl_in = 1'b1; else sda_in = 1'b1;
    tick(12);
    chk({req, " restored"}, int'(line == 0 ? scl_out : sda_out), 1);
  endtask

  task automatic t_reset;
    chk("R1 scl_out", int'(scl_out), 1);
    chk("R1 sda_out", int'(sda_out), 1);
    chk("R1 comp", int'(scl_comp), 13);
  endtask

  task automatic t_comp;
    for (int e = 0; e < 2; e++) begin
      for (int t = 0; t < 8; t++) begin
        int ex;
        scl_filt_en = e[0];
        scl_thr = 3'(t);
        tick(1);
        ex = (e == 0) ? 7 : ((t <= 2) ? 8 : t + 6);
        chk($sformatf("R8 en=%0d thr=%0d", e, t), int'(scl_comp), ex);
      end
    end
    scl_filt_en = 1'b1;
    scl_thr = 3'd7;
    tick(2);
  endtask

  task automatic t_latency;
    for (int t = 1; t < 8; t++) begin
      scl_thr = 3'(t);
      tick(1);
      step_latency(0, t, $sformatf("R3 scl thr=%0d", t));
    end
    sda_thr = 3'd5;
    tick(1);
    step_latency(1, 5, "R3 sda thr=5");
  endtask

  task automatic t_short;
    bit s;
    scl_thr = 3'd4;
    tick(1);
    pulse_seen(0, 3, s);
    chk("R4 pulse 3 < thr 4 dropped", int'(s), 0);
    pulse_seen(0, 4, s);
    chk("R4 pulse 4 = thr 4 passed", int'(s), 1);
  endtask

  task automatic t_restart;
    bit s;
    scl_thr = 3'd4;
    tick(1);
    s = 1'b0;
    scl_in = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(1); if (!scl_out) s = 1'b1; end
    scl_in = 1'b1;
    tick(1); if (!scl_out) s = 1'b1;
    scl_in = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(1); if (!scl_out) s = 1'b1; end
    scl_in = 1'b1;
    for (int i = 0; i < 14; i++) begin tick(1); if (!scl_out) s = 1'b1; end
    chk("R5 split pulses not summed", int'(s), 0);
  endtask

  task automatic t_thr0;
    bit s;
    scl_thr = 3'd0;
    tick(1);
    step_latency(0, 1, "R6 thr0 latency");
    pulse_seen(0, 1, s);
    chk("R6 thr0 one-cycle pulse", int'(s), 1);
  endtask

  task automatic t_disabled;
    bit s;
    scl_filt_en = 1'b0;
    scl_thr = 3'd7;
    tick(1);
    step_latency(0, 1, "R2 bypass latency");
    pulse_seen(0, 1, s);
    chk("R2 bypass one-cycle pulse", int'(s), 1);
    scl_filt_en = 1'b1;
    tick(2);
  endtask

  task automatic t_independent;
    bit s_scl, s_sda;
    scl_filt_en = 1'b1; scl_thr = 3'd7;
    sda_filt_en = 1'b0; sda_thr = 3'd7;
    tick(2);
    s_scl = 1'b0; s_sda = 1'b0;
    scl_in = 1'b0; sda_in = 1'b0;
    for (int i = 0; i < 2; i++) begin
      tick(1); if (!scl_out) s_scl = 1'b1; if (!sda_out) s_sda = 1'b1;
    end
    scl_in = 1'b1; sda_in = 1'b1;
    for (int i = 0; i < 14; i++) begin
      tick(1); if (!scl_out) s_scl = 1'b1; if (!sda_out) s_sda = 1'b1;
    end
    chk("R7 scl filtered", int'(s_scl), 0);
    chk("R7 sda bypassed", int'(s_sda), 1);
    sda_filt_en = 1'b1;
    tick(2);
  endtask

  initial begin
    tick(4);
    t_reset();
    rst = 1'b0;
    tick(3);
    t_comp();
    t_latency();
    t_short();
    t_restart();
    t_thr0();
    t_disabled();
    t_independent();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule